// File: doc/BRIEF.md
# Vector Saturating Count-Based Incrementer

This block takes one instruction word, one vector operand and the current vector length, and returns the vector with every 64-bit lane raised by the same scalar amount. Each lane result is clamped to the unsigned 64-bit range. The amount is worked out at run time in three steps. A 5-bit pattern code is decoded against the number of lanes that the current vector length provides, which gives an active element count. That count is then multiplied by a 4-bit immediate plus one.

The datapath is built for the largest vector length. Lanes beyond the current length come out as zero. A word whose fixed opcode bits do not match is not accepted, and no result is produced for it. An accepted word yields a registered result one cycle later. That result carries the register index taken from the word and a valid flag.

Top module: `vec_sat_count_inc`

## Requirements
- R1: A word is accepted only when bits 31:20 equal 000001001110 and bits 15:10 equal 110001. For any other word, `res_valid` stays low in the following cycle.
- R2: The lane count is `vl_bits`/64, where `vl_bits` is a multiple of 128 from 128 to 2048. Lanes at or above that count are output as zero.
- R3: Each active lane result is the lane value plus the increment. When that sum exceeds 2^64−1, the result is 2^64−1.
- R4: Pattern codes 1 to 8 (bits 9:5) ask for that many elements. Codes 9 to 13 ask for 16, 32, 64, 128 and 256. The requested number is used only when it does not exceed the lane count; otherwise the count is zero.
- R5: Pattern code 0 gives the largest power of two that does not exceed the lane count.
- R6: Pattern code 29 gives the lane count rounded down to a multiple of 4. Code 30 gives it rounded down to a multiple of 3.
- R7: Pattern code 31 gives the full lane count.
- R8: Pattern codes 14 to 28 give a count of zero, so the active lanes pass through unchanged.
- R9: The increment is the count times (bits 19:16 + 1), and every active lane receives the same increment.
- R10: An accepted word with `in_valid` high produces `res_valid` high with the result on the next cycle. In that cycle `res_reg` equals bits 4:0 of the word. With `in_valid` low, no result is produced.
- R11: A synchronous reset clears `res_valid` and `res_vec` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word and operand are valid |
| insn | input | 32 | Instruction word |
| vl_bits | input | VL_W (12) | Current vector length in bits |
| vec_in | input | MAX_VL (2048) | Source vector, lane 0 in the low bits |
| res_valid | output | 1 | Result valid, one cycle after an accepted input |
| res_reg | output | 5 | Destination register index |
| res_vec | output | MAX_VL (2048) | Result vector |

## Verification
A wrong count decode or a wrong multiplier shows up in the very next valid result as a uniform offset error across all active lanes. A bad saturation path shows up only in lanes near the top of the range, so those lanes are filled with values just below 2^64−1 at graded distances. An error in the lane-activity comparison appears as non-zero data above the current vector length, or as zeroed data below it, on the first result at a short length. Opcode-match faults show as an unexpected or missing `res_valid` one cycle after the word.

// File: rtl/vinc_pkg.sv
package vinc_pkg;
  localparam logic [11:0] OPC_HI  = 12'b000001001110;
  localparam logic [5:0]  OPC_MID = 6'b110001;

  localparam logic [4:0] PAT_POW2 = 5'd0;
  localparam logic [4:0] PAT_MUL4 = 5'd29;
  localparam logic [4:0] PAT_MUL3 = 5'd30;
  localparam logic [4:0] PAT_ALL  = 5'd31;

  typedef struct packed {
    logic       ok;
    logic [4:0] pat;
    logic [4:0] mult;
    logic [4:0] rd;
  } insn_fields_t;
endpackage

// File: rtl/vinc_insn_dec.sv
module vinc_insn_dec
  import vinc_pkg::*;
(
  input  logic [31:0]  insn,
  output insn_fields_t fields
);
  always_comb begin
    fields.ok   = (insn[31:20] == OPC_HI) && (insn[15:10] == OPC_MID);
    fields.pat  = insn[9:5];
    fields.mult = {1'b0, insn[19:16]} + 5'd1;
    fields.rd   = insn[4:0];
  end
endmodule

// File: rtl/vinc_count_dec.sv
module vinc_count_dec
  import vinc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [4:0]       pat,
  input  logic [CNT_W-1:0] lanes,
  output logic [CNT_W-1:0] cnt
);
  localparam int CW = (CNT_W > 9) ? CNT_W : 9;

  logic [CW-1:0]    fixed_n;
  logic             is_fixed;
  logic [CNT_W-1:0] pow;
  logic [CNT_W-1:0] by4;
  logic [CNT_W-1:0] by3;

  always_comb begin
    is_fixed = 1'b0;
    fixed_n  = '0;
    if (pat >= 5'd1 && pat <= 5'd8) begin
      is_fixed = 1'b1;
      fixed_n  = CW'(pat);
    end else if (pat >= 5'd9 && pat <= 5'd13) begin
      is_fixed = 1'b1;
      fixed_n  = CW'(16) << (pat - 5'd9);
    end
  end

  always_comb begin
    pow = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (lanes[i]) begin
        pow    = '0;
        pow[i] = 1'b1;
      end
    end
  end

  assign by4 = {lanes[CNT_W-1:2], 2'b00};
  assign by3 = lanes - (lanes % CNT_W'(3));

  always_comb begin
    case (pat)
      PAT_POW2: cnt = pow;
      PAT_MUL4: cnt = by4;
      PAT_MUL3: cnt = by3;
      PAT_ALL:  cnt = lanes;
      default:  cnt = (is_fixed && (fixed_n <= CW'(lanes))) ? CNT_W'(fixed_n) : '0;
    endcase
  end
endmodule

// File: rtl/vinc_lane_sat.sv
module vinc_lane_sat #(
  parameter int LANE_W = 64,
  parameter int INC_W  = 11
) (
  input  logic [LANE_W-1:0] a,
  input  logic [INC_W-1:0]  inc,
  input  logic              active,
  output logic [LANE_W-1:0] y
);
  logic [LANE_W:0] sum;

  assign sum = {1'b0, a} + (LANE_W+1)'(inc);

  always_comb begin
    if (!active)          y = '0;
    else if (sum[LANE_W]) y = '1;
    else                  y = sum[LANE_W-1:0];
  end
endmodule

// File: rtl/vec_sat_count_inc.sv
module vec_sat_count_inc
  import vinc_pkg::*;
#(
  parameter int LANE_W = 64,
  parameter int MAX_VL = 2048,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       insn,
  input  logic [VL_W-1:0]   vl_bits,
  input  logic [MAX_VL-1:0] vec_in,
  output logic              res_valid,
  output logic [4:0]        res_reg,
  output logic [MAX_VL-1:0] res_vec
);
  localparam int MAX_LANES = MAX_VL / LANE_W;
  localparam int CNT_W     = $clog2(MAX_LANES + 1);
  localparam int INC_W     = CNT_W + 5;
  localparam int LSH       = $clog2(LANE_W);

  insn_fields_t      fields;
  logic [CNT_W-1:0]  lanes;
  logic [CNT_W-1:0]  cnt;
  logic [INC_W-1:0]  inc;
  logic [MAX_VL-1:0] lane_y;
  logic              take;

  vinc_insn_dec u_dec (
    .insn   (insn),
    .fields (fields)
  );

  assign lanes = CNT_W'(vl_bits >> LSH);

  vinc_count_dec #(.CNT_W(CNT_W)) u_cnt (
    .pat   (fields.pat),
    .lanes (lanes),
    .cnt   (cnt)
  );

  assign inc  = INC_W'(cnt) * INC_W'(fields.mult);
  assign take = in_valid && fields.ok;

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    vinc_lane_sat #(.LANE_W(LANE_W), .INC_W(INC_W)) u_lane (
      .a      (vec_in[g*LANE_W +: LANE_W]),
      .inc    (inc),
      .active (CNT_W'(g) < lanes),
      .y      (lane_y[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_reg   <= '0;
      res_vec   <= '0;
    end else begin
      res_valid <= take;
      if (take) begin
        res_reg <= fields.rd;
        res_vec <= lane_y;
      end
    end
  end
endmodule

// File: rtl/vinc_checker.sv
module vinc_checker #(
  parameter int LANE_W = 64,
  parameter int MAX_VL = 2048,
  parameter int VL_W   = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       insn,
  input logic [VL_W-1:0]   vl_bits,
  input logic [MAX_VL-1:0] vec_in,
  input logic              res_valid,
  input logic [4:0]        res_reg,
  input logic [MAX_VL-1:0] res_vec
);
  logic word_ok;
  logic pat_unknown;
  assign word_ok     = (insn[31:20] == 12'b000001001110) && (insn[15:10] == 6'b110001);
  assign pat_unknown = (insn[9:5] >= 5'd14) && (insn[9:5] <= 5'd28);

  assert_reset_R11: assert property (@(posedge clk) rst |=> (!res_valid && res_vec == '0));

  assert_reject_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !word_ok) |=> !res_valid);

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_ok) |=> res_valid);

  assert_reg_echo_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_ok) |=> (res_reg == $past(insn[4:0])));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_ok) |=> (res_vec[LANE_W-1:0] >= $past(vec_in[LANE_W-1:0])));

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_ok && vl_bits == VL_W'(128)) |=> (res_vec[MAX_VL-1:128] == '0));

  assert_unknown_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_ok && pat_unknown) |=> (res_vec[127:0] == $past(vec_in[127:0])));
endmodule

bind vec_sat_count_inc vinc_checker #(.LANE_W(LANE_W), .MAX_VL(MAX_VL), .VL_W(VL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .insn      (insn),
  .vl_bits   (vl_bits),
  .vec_in    (vec_in),
  .res_valid (res_valid),
  .res_reg   (res_reg),
  .res_vec   (res_vec)
);

// File: tb/sim_vec_sat_count_inc.sv
module sim_vec_sat_count_inc;
  localparam int MAX_VL = 2048;
  localparam int NL     = MAX_VL / 64;

  typedef struct {
    logic [MAX_VL-1:0] vec;
    logic [4:0]        rd;
    string             tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [31:0]       insn = '0;
  logic [11:0]       vl_bits = 12'd128;
  logic [MAX_VL-1:0] vec_in = '0;
  logic              res_valid;
  logic [4:0]        res_reg;
  logic [MAX_VL-1:0] res_vec;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  item_t sb[$];

  always #10 clk = ~clk;

  vec_sat_count_inc u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .vl_bits(vl_bits),
    .vec_in(vec_in), .res_valid(res_valid), .res_reg(res_reg), .res_vec(res_vec)
  );

  function automatic logic [31:0] mk(int imm4, int pat, int rd);
    return {12'b000001001110, 4'(imm4), 6'b110001, 5'(pat), 5'(rd)};
  endfunction

  function automatic logic [MAX_VL-1:0] fill(longint unsigned base, longint unsigned step);
    logic [MAX_VL-1:0] v;
    for (int i = 0; i < NL; i++) v[i*64 +: 64] = base - step * longint'(i);
    return v;
  endfunction

  function automatic int want_count(int p, int n);
    int c;
    int k;
    c = 0;
    if (p == 0) begin
      c = 1;
      while (c * 2 <= n) c = c * 2;
    end else if (p >= 1 && p <= 8) c = (p <= n) ? p : 0;
    else if (p >= 9 && p <= 13) begin
      k = 16 << (p - 9);
      c = (k <= n) ? k : 0;
    end else if (p == 29) c = (n / 4) * 4;
    else if (p == 30) c = (n / 3) * 3;
    else if (p == 31) c = n;
    return c;
  endfunction

  function automatic logic [MAX_VL-1:0] model(logic [31:0] w, int vl, logic [MAX_VL-1:0] v);
    logic [MAX_VL-1:0] r;
    longint unsigned a, s, incr;
    int n;
    n    = vl / 64;
    incr = longint'(want_count(int'(w[9:5]), n) * (int'(w[19:16]) + 1));
    r    = '0;
    for (int i = 0; i < NL; i++) begin
      if (i < n) begin
        a = v[i*64 +: 64];
        s = a + incr;
        if (s < a) s = '1;
        r[i*64 +: 64] = s;
      end
    end
    return r;
  endfunction

  task automatic send(logic [31:0] w, int vl, logic [MAX_VL-1:0] v, string tag);
    item_t it;
    in_valid = 1'b1;
    insn     = w;
    vl_bits  = 12'(vl);
    vec_in   = v;
    if (w[31:20] == 12'b000001001110 && w[15:10] == 6'b110001) begin
      it.vec = model(w, vl, v);
      it.rd  = w[4:0];
      it.tag = tag;
      sb.push_back(it);
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_novalid(string tag);
    n_chk++;
    if (res_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: res_valid got %b expected 0", tag, res_valid);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    item_t it;
    if (!rst && res_valid) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R1: unexpected result reg %0d, expected none", res_reg);
      end else begin
        it = sb.pop_front();
        if (res_vec !== it.vec || res_reg !== it.rd) begin
          n_bad++;
          $display("FAIL %s: got reg %0d vec %h expected reg %0d vec %h",
                   it.tag, res_reg, res_vec, it.rd, it.vec);
        end
      end
    end
  end

  initial begin
    logic [MAX_VL-1:0] va, vs;
    va = fill(64'h1234_5678_0000_1000, 64'h0000_0001_0000_0011);
    vs = fill(64'hFFFF_FFFF_FFFF_FFFF, 64'd40);
    repeat (3) @(negedge clk);
    // R11: reset state
    n_chk++;
    if (res_valid !== 1'b0 || res_vec !== '0) begin
      n_bad++;
      $display("FAIL R11: valid %b vec nonzero=%b expected 0/0", res_valid, |res_vec);
    end
    rst = 1'b0;
    @(negedge clk);

    send(mk(0, 1, 3), 128, va, "R4 VL1 at 2 lanes");
    send(mk(0, 8, 4), 256, va, "R4 count 8 exceeds 4 lanes");
    send(mk(2, 8, 5), 512, va, "R4 count 8 at 8 lanes x3");
    send(mk(1, 10, 6), 2048, va, "R4 count 32 at 32 lanes");
    send(mk(15, 13, 7), 2048, va, "R4 count 256 exceeds lanes");
    send(mk(0, 0, 8), 384, va, "R5 pow2 of 6 lanes");
    send(mk(3, 0, 9), 1920, va, "R5 pow2 of 30 lanes");
    send(mk(1, 29, 10), 640, va, "R6 mul4 of 10 lanes");
    send(mk(4, 30, 11), 640, va, "R6 mul3 of 10 lanes");
    send(mk(0, 31, 12), 128, va, "R2 R7 all at min length");
    send(mk(15, 31, 13), 2048, vs, "R3 saturation at 512 increment");
    send(mk(7, 14, 14), 1024, vs, "R8 unknown code 14");
    send(mk(15, 28, 15), 2048, va, "R8 unknown code 28");
    send(mk(9, 5, 31), 1152, va, "R9 count 5 x10 every lane");
    idle(1);
    check_novalid("R10 no result without in_valid");
    idle(1);
    check_novalid("R10 quiet line");
    send(mk(0, 31, 1) ^ 32'h8000_0000, 2048, va, "R1 bad high opcode");
    check_novalid("R1 bad high opcode");
    send(mk(0, 31, 1) ^ 32'h0000_0400, 2048, va, "R1 bad middle opcode");
    check_novalid("R1 bad middle opcode");
    send(mk(15, 30, 2), 256, vs, "R3 R6 mul3 saturating 2 lanes at 256");
    idle(3);

    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R10: %0d results missing, expected 0", sb.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule